// File: doc/BRIEF.md
# Prioritised Three-Level Interrupt Controller

This block gathers interrupt requests from thirteen peripheral sources into a 32-bit pending word. Each source owns a fixed and irregular bit position in that word. A separate 32-bit enable word selects which pending bits may interrupt the processor. From the bits that are both pending and enabled, the block forms a registered 3-bit processor priority level and an 8-bit autovector number. Only three levels are ever produced (3, 5 and 6), and each level has its own vector.

A source sets its pending bit when its request rises and clears the bit when the request falls. Between those events, the host may overwrite either word in full. A separate peripheral-control write drives pending bit 26 directly from bit 4 of the written byte.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending word, the enable word, `ipl_o` and `vec_o` are all zero.
- R2: A rising request sets the source's pending bit. The source-to-bit mapping by request index is: 0→2, 1→3, 2→5, 3→7, 4→9, 5→10, 6→12, 7→17, 8→21, 9→23, 10→26, 11→27, 12→28.
- R3: A falling request clears the source's pending bit. A request that is held steady leaves its bit unchanged.
- R4: When `wr_en` is high, the host write replaces the whole pending word (`wr_sel`=0) or the whole enable word (`wr_sel`=1), and the new value appears on `status_o` or `mask_o`.
- R5: A write to the peripheral control byte (`dma_ctl_wr`) copies bit 4 of `dma_ctl_data` into pending bit 26 and leaves every other pending bit unchanged.
- R6: The level is the highest group level that has at least one bit both pending and enabled. Bits 2, 3, 5, 7, 9, 10 and 12 form level 3. Bit 17 forms level 5. Bits 21, 23, 26, 27 and 28 form level 6. Pending bits that are not enabled have no effect on the level.
- R7: `vec_o` is 27 for level 3, 29 for level 5, 30 for level 6, and 0 when the level is 0.
- R8: `ipl_o` and `vec_o` follow a change of the pending or enable word one clock later.
- R9: If a request edge and a host or control write touch the same pending bit in the same cycle, the request edge wins. The other bits still take the written value.
- R10: Pending bits outside the three groups never raise the level, even when they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 13 | Level requests, indexed as in R2 |
| wr_en | input | 1 | Host word write strobe |
| wr_sel | input | 1 | 0 = pending word, 1 = enable word |
| wr_data | input | 32 | Host write data |
| dma_ctl_wr | input | 1 | Peripheral control byte write strobe |
| dma_ctl_data | input | 8 | Control byte; bit 4 drives pending bit 26 |
| status_o | output | 32 | Pending word |
| mask_o | output | 32 | Enable word |
| ipl_o | output | 3 | Registered processor priority level |
| vec_o | output | 8 | Registered autovector number |

## Verification
The edge properties assume that `src_req` stays low throughout reset. They also assume that requests, strobes and data change only between clock edges, so the previous sample of each request is the value the design last saw. The bench meets both assumptions: it holds every input at zero during reset and drives all inputs on the falling clock edge. Each stimulus is held for exactly one rising edge, and the bench then idles for one edge so that the registered level has settled before it is compared.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NSRC   = 13,
  parameter int unsigned DW     = 32,
  parameter logic [7:0]  VEC_L3 = 8'd27,
  parameter logic [7:0]  VEC_L5 = 8'd29,
  parameter logic [7:0]  VEC_L6 = 8'd30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            dma_ctl_wr,
  input  logic [7:0]      dma_ctl_data,
  output logic [DW-1:0]   status_o,
  output logic [DW-1:0]   mask_o,
  output logic [2:0]      ipl_o,
  output logic [7:0]      vec_o
);

  localparam logic [DW-1:0] GRP3 = DW'(32'h0000_16AC);
  localparam logic [DW-1:0] GRP5 = DW'(32'h0002_0000);
  localparam logic [DW-1:0] GRP6 = DW'(32'h1CA0_0000);
  localparam int unsigned   CTL_BIT = 26;

  function automatic int unsigned bit_of(input int unsigned idx);
    case (idx)
      0:  bit_of = 2;
      1:  bit_of = 3;
      2:  bit_of = 5;
      3:  bit_of = 7;
      4:  bit_of = 9;
      5:  bit_of = 10;
      6:  bit_of = 12;
      7:  bit_of = 17;
      8:  bit_of = 21;
      9:  bit_of = 23;
      10: bit_of = 26;
      11: bit_of = 27;
      default: bit_of = 28;
    endcase
  endfunction

  logic [NSRC-1:0] req_q;
  logic [DW-1:0]   stat_q, mask_q, stat_d, pend;
  logic [2:0]      lvl;

  always_comb begin
    stat_d = stat_q;
    if (wr_en && !wr_sel) stat_d = wr_data;
    if (dma_ctl_wr)       stat_d[CTL_BIT] = dma_ctl_data[4];
    for (int i = 0; i < NSRC; i++)
      if (src_req[i] != req_q[i]) stat_d[bit_of(i)] = src_req[i];
  end

  assign pend = stat_q & mask_q;
  assign lvl  = |(pend & GRP6) ? 3'd6 :
                |(pend & GRP5) ? 3'd5 :
                |(pend & GRP3) ? 3'd3 : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      ipl_o  <= '0;
      vec_o  <= '0;
    end else begin
      req_q  <= src_req;
      stat_q <= stat_d;
      if (wr_en && wr_sel) mask_q <= wr_data;
      ipl_o  <= lvl;
      case (lvl)
        3'd6:    vec_o <= VEC_L6;
        3'd5:    vec_o <= VEC_L5;
        3'd3:    vec_o <= VEC_L3;
        default: vec_o <= 8'd0;
      endcase
    end
  end

  assign status_o = stat_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] src_req,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic        dma_ctl_wr,
  input logic [7:0]  dma_ctl_data,
  input logic [31:0] status_o,
  input logic [31:0] mask_o,
  input logic [2:0]  ipl_o,
  input logic [7:0]  vec_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (status_o == 0 && mask_o == 0 && ipl_o == 0 && vec_o == 0));

  p_rise_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req[0] && !$past(src_req[0])) |=> status_o[2]);

  p_rise_serial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req[7] && !$past(src_req[7])) |=> status_o[17]);

  p_fall_txdma_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_req[12] && $past(src_req[12])) |=> !status_o[28]);

  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> mask_o == $past(wr_data));

  p_ctl_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ctl_wr && $stable(src_req)) |=> status_o[26] == $past(dma_ctl_data[4]));

  p_no_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == 0) |=> ipl_o == 0);

  p_vec_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_o == 3'd0 && vec_o == 8'd0) || (ipl_o == 3'd3 && vec_o == 8'd27) ||
    (ipl_o == 3'd5 && vec_o == 8'd29) || (ipl_o == 3'd6 && vec_o == 8'd30));

  p_level_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status_o) && $stable(mask_o) |=> $stable(ipl_o));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .dma_ctl_wr(dma_ctl_wr), .dma_ctl_data(dma_ctl_data),
  .status_o(status_o), .mask_o(mask_o), .ipl_o(ipl_o), .vec_o(vec_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] src_req = '0;
  logic        wr_en = 0, wr_sel = 0, dma_ctl_wr = 0;
  logic [31:0] wr_data = '0;
  logic [7:0]  dma_ctl_data = '0;
  logic [31:0] status_o, mask_o;
  logic [2:0]  ipl_o;
  logic [7:0]  vec_o;

  irq_prio_ctrl i_irq_prio_ctrl (.*);

  always #10 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] st;
    logic [31:0] mk;
    logic [2:0]  lv;
    logic [7:0]  vc;
  } exp_t;

  exp_t q[$];
  event pushed;
  int n_run = 0, n_fail = 0;
  logic [31:0] m_st = '0, m_mk = '0;
  logic [12:0] m_req = '0;
  bit done = 0;

  function automatic int bpos(int i);
    int t[13] = '{2, 3, 5, 7, 9, 10, 12, 17, 21, 23, 26, 27, 28};
    return t[i];
  endfunction

  function automatic logic [2:0] lvl_of(logic [31:0] p);
    if (p & 32'h1CA0_0000) return 3'd6;
    if (p & 32'h0002_0000) return 3'd5;
    if (p & 32'h0000_16AC) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [7:0] vec_of(logic [2:0] l);
    case (l)
      3'd6: return 8'd30;
      3'd5: return 8'd29;
      3'd3: return 8'd27;
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.tag = tag; e.st = m_st; e.mk = m_mk;
    e.lv = lvl_of(m_st & m_mk); e.vc = vec_of(e.lv);
    q.push_back(e);
    ->pushed;
  endtask

  task automatic step(string tag, logic [12:0] req, bit we, bit sel,
                      logic [31:0] d, bit dw, logic [7:0] dd);
    logic [2:0] old_lv;
    old_lv = lvl_of(m_st & m_mk);
    src_req = req; wr_en = we; wr_sel = sel; wr_data = d;
    dma_ctl_wr = dw; dma_ctl_data = dd;
    if (we && !sel) m_st = d;
    if (we && sel)  m_mk = d;
    if (dw) m_st[26] = dd[4];
    for (int i = 0; i < 13; i++)
      if (req[i] != m_req[i]) m_st[bpos(i)] = req[i];
    m_req = req;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; dma_ctl_wr = 0;
    check({"R8 lag ", tag}, 64'(ipl_o), 64'(old_lv));
    @(posedge clk);
    @(negedge clk);
    push(tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(pushed);
      while (q.size() != 0) begin
        e = q.pop_front();
        check({e.tag, " status"}, 64'(status_o), 64'(e.st));
        check({e.tag, " mask"},   64'(mask_o),   64'(e.mk));
        check({e.tag, " ipl"},    64'(ipl_o),    64'(e.lv));
        check({e.tag, " vec"},    64'(vec_o),    64'(e.vc));
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [12:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push("R1 reset");
    step("R4 mask all", '0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    r = '0;
    for (int i = 0; i < 13; i++) begin
      r[i] = 1'b1;
      step($sformatf("R2 R6 R7 rise src%0d", i), r, 0, 0, 0, 0, 0);
    end
    step("R6 mask off level6", r, 1, 1, 32'h0002_16AC, 0, 0);
    step("R6 mask off level5", r, 1, 1, 32'h0000_16AC, 0, 0);
    step("R6 mask only bit 12", r, 1, 1, 32'h0000_1000, 0, 0);
    step("R4 R6 mask all again", r, 1, 1, 32'hFFFF_FFFF, 0, 0);
    for (int i = 12; i >= 0; i--) begin
      r[i] = 1'b0;
      step($sformatf("R3 R6 fall src%0d", i), r, 0, 0, 0, 0, 0);
    end
    step("R3 steady low", r, 0, 0, 0, 0, 0);
    step("R5 ctl set", r, 0, 0, 0, 1, 8'h10);
    step("R5 ctl clear others kept", r, 1, 0, 32'h0000_0004, 0, 0);
    step("R5 ctl set with bit2", r, 0, 0, 0, 1, 8'hFF);
    step("R5 ctl clear", r, 0, 0, 0, 1, 8'hEF);
    step("R10 ungrouped bits", r, 1, 0, 32'hE35D_E953, 0, 0);
    step("R4 status write all", r, 1, 0, 32'hFFFF_FFFF, 0, 0);
    step("R4 status clear", r, 1, 0, 32'h0000_0000, 0, 0);
    r[7] = 1'b1;
    step("R9 rise beats host clear", r, 1, 0, 32'h0000_0000, 0, 0);
    r[7] = 1'b0;
    step("R9 fall beats host set", r, 1, 0, 32'h0002_0008, 0, 0);
    r[10] = 1'b1;
    step("R9 rise beats ctl clear", r, 0, 0, 0, 1, 8'h00);
    r[10] = 1'b0;
    step("R9 fall beats ctl set", r, 0, 0, 0, 1, 8'h10);
    done = 1;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule